// File: doc/BRIEF.md
# Prioritised Bus Interrupter with Vector Response

This block raises a prioritised interrupt request on a VME-style backplane in response to a local interrupt event. It then answers the interrupt-acknowledge cycle that the bus master runs for that request. Software or a local controller writes two byte registers through a small write port:

- a priority level from 1 to 7;
- an 8-bit status/ID vector.

A single-cycle pulse on the local event input latches a pending request. That request appears as one hot bit on the 7-bit request output.

During an acknowledge cycle the master does the following in order:

1. It pulls the acknowledge line low.
2. It places the level being serviced on address bits 3:1.
3. It asserts the address strobe and the data strobe pair.

The block samples these bus controls through two-flop synchronisers. If the cycle's level equals the programmed level and a request is pending, the block places the vector on the low data byte and holds the transfer-acknowledge enable. When the master lifts both data strobes, the block drops the data, drops the acknowledge and clears the request.

In every other case the block forwards the incoming daisy-chain signal to the next board. This covers a level mismatch and a cycle that arrives with nothing pending.

Top module: `irqr_top`

## Requirements
- R1: While reset is asserted, the request output is 0000000, the vector output is 0x00, the transfer-acknowledge enable is low and the daisy-chain output is high.
- R2: With a programmed level N in 1..7, a local event pulse makes the request output equal to 1 shifted left by N-1. This result is visible in the cycle after the edge that samples the pulse, and at most one request bit is ever set.
- R3: A programmed level of 0, or any level above 7, disables the interrupter. A local event then sets no request bit, and the request output stays 0000000.
- R4: If the vector register has never been written since reset, a matching acknowledge cycle returns the vector 0x00.
- R5: An acknowledge cycle has the acknowledge line low, the incoming chain low, the address strobe low and at least one data strobe low. When its address bits 3:1 equal the programmed level and a request is pending, the block drives the vector on bits 7:0 and raises the transfer-acknowledge enable. This happens on the third clock edge after the strobes change, and not before.
- R6: The transfer-acknowledge enable and the vector stay asserted as long as either data strobe is low. On the third edge after both strobes are high, they drop and the request output returns to 0000000.
- R7: An acknowledge cycle with a mismatching level, or with no pending request, drives the daisy-chain output low on the third edge. In that case the vector output stays 0x00 and the transfer-acknowledge enable stays low. A pending request survives such a cycle.
- R8: After a request is cleared by an acknowledge, the request output stays 0000000 until a new local event arrives.
- R9: Register writes select by a one-bit selector: 0 writes the level and 1 writes the vector. Writing one register leaves the other register, and any pending request, unchanged.
- R10: Forwarding on the daisy chain ends on the third edge after the address strobe or the incoming chain returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_evt | input | 1 | Local interrupt event, one-cycle pulse |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 level, 1 vector |
| cfg_wdata | input | 8 | Register write byte |
| irq_req | output | 7 | Active-high request, bit N-1 for level N |
| ack_cycle_n | input | 1 | Bus acknowledge-cycle indicator, active low |
| chain_in_n | input | 1 | Incoming daisy-chain grant, active low |
| chain_out_n | output | 1 | Outgoing daisy-chain grant, active low |
| addr_strobe_n | input | 1 | Bus address strobe, active low |
| data_strobe_n | input | 2 | Bus data strobes, active low (bit 1 and bit 0) |
| lvl_addr | input | 3 | Address bits 3:1 carrying the acknowledged level |
| vec_out | output | 8 | Status/ID vector on data bits 7:0, zero when idle |
| xfer_ack_en | output | 1 | Transfer-acknowledge enable, active high |

## Verification
There are four latencies to observe:

- **Request set:** a local event shows on the request output one edge after it is sampled.
- **Bus response:** every bus-side result lags its stimulus by three edges. Two edges are spent in the synchronisers and one in the acknowledge state machine. This holds for vector drive, acknowledge, forwarding, release and request clearing.
- **Lower bound:** the bench drives the bus at a falling edge. It checks at the falling edge after the second rising edge that nothing has moved yet.
- **Result:** it checks at the falling edge after the third rising edge that the result has arrived.

Register writes and event pulses are sampled at the falling edge right after the rising edge that captures them. Every level is swept against every acknowledged level, so each match and each mismatch is checked at these fixed offsets.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RESPOND = 2'd1,
    ST_PASS    = 2'd2
  } ack_state_t;

endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/irqr_cfg.sv
module irqr_cfg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] level,
  output logic [CFG_W-1:0] vector
);

  logic             level_en;
  logic             vector_en;
  logic [CFG_W-1:0] level_q;
  logic [CFG_W-1:0] level_d;
  logic [CFG_W-1:0] vector_q;
  logic [CFG_W-1:0] vector_d;

  assign level_en  = cfg_we & ~cfg_sel;
  assign vector_en = cfg_we &  cfg_sel;

  always_comb begin
    level_d  = level_q;
    vector_d = vector_q;
    if (level_en) begin
      level_d = cfg_wdata;
    end
    if (vector_en) begin
      vector_d = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      vector_q <= '0;
    end else begin
      if (level_en) begin
        level_q <= level_d;
      end
      if (vector_en) begin
        vector_q <= vector_d;
      end
    end
  end

  assign level  = level_q;
  assign vector = vector_q;

endmodule

// File: rtl/irqr_pend.sv
module irqr_pend #(
  parameter int LEVELS = 7,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_evt,
  input  logic [CFG_W-1:0]  level,
  input  logic              clear,
  output logic              pending,
  output logic [LEVELS-1:0] irq_req
);

  logic lvl_ok;
  logic pend_q;
  logic pend_d;
  logic pend_en;

  assign lvl_ok = (level != '0) && (level <= CFG_W'(LEVELS));

  // a new event has priority over a clear landing on the same edge
  always_comb begin
    pend_d = pend_q;
    if (int_evt && lvl_ok) begin
      pend_d = 1'b1;
    end else if (clear) begin
      pend_d = 1'b0;
    end
  end

  assign pend_en = (int_evt && lvl_ok) || clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_req
    assign irq_req[i] = pend_q && (level == CFG_W'(i + 1));
  end

  assign pending = pend_q;

endmodule

// File: rtl/irqr_ack_fsm.sv
module irqr_ack_fsm
  import irqr_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int ADR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_s_n,
  input  logic             chain_s_n,
  input  logic             as_s_n,
  input  logic [1:0]       ds_s_n,
  input  logic [ADR_W-1:0] lvl_addr,
  input  logic [CFG_W-1:0] level,
  input  logic [CFG_W-1:0] vector,
  input  logic             pending,
  output logic [CFG_W-1:0] vec_out,
  output logic             xfer_ack_en,
  output logic             chain_out_n,
  output logic             ack_done
);

  ack_state_t       st_q;
  ack_state_t       st_d;
  logic [CFG_W-1:0] vec_q;
  logic             cyc_start;
  logic             hit;
  logic             vec_load;

  assign cyc_start = !ack_s_n && !chain_s_n && !as_s_n && (ds_s_n != 2'b11);
  assign hit       = pending && (level != '0) && (CFG_W'(lvl_addr) == level);

  always_comb begin
    st_d     = st_q;
    ack_done = 1'b0;
    vec_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cyc_start) begin
          if (hit) begin
            st_d     = ST_RESPOND;
            vec_load = 1'b1;
          end else begin
            st_d = ST_PASS;
          end
        end
      end
      ST_RESPOND: begin
        if (ds_s_n == 2'b11) begin
          st_d     = ST_IDLE;
          ack_done = 1'b1;
        end
      end
      ST_PASS: begin
        if (as_s_n || chain_s_n) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_load) begin
      vec_q <= vector;
    end
  end

  assign xfer_ack_en = (st_q == ST_RESPOND);
  assign vec_out     = xfer_ack_en ? vec_q : '0;
  assign chain_out_n = (st_q != ST_PASS);

endmodule

// File: rtl/irqr_top.sv
module irqr_top #(
  parameter int LEVELS      = 7,
  parameter int CFG_W       = 8,
  parameter int ADR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_evt,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [LEVELS-1:0] irq_req,
  input  logic              ack_cycle_n,
  input  logic              chain_in_n,
  output logic              chain_out_n,
  input  logic              addr_strobe_n,
  input  logic [1:0]        data_strobe_n,
  input  logic [ADR_W-1:0]  lvl_addr,
  output logic [CFG_W-1:0]  vec_out,
  output logic              xfer_ack_en
);

  localparam int BUS_W = 5;

  logic             rst_int_n;
  logic [BUS_W-1:0] bus_raw;
  logic [BUS_W-1:0] bus_s;
  logic [CFG_W-1:0] level;
  logic [CFG_W-1:0] vector;
  logic             pending;
  logic             ack_done;

  irqr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  assign bus_raw = {ack_cycle_n, chain_in_n, addr_strobe_n, data_strobe_n};

  irqr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b1}})) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (bus_raw),
    .q     (bus_s)
  );

  irqr_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .level     (level),
    .vector    (vector)
  );

  irqr_pend #(.LEVELS(LEVELS), .CFG_W(CFG_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .int_evt (int_evt),
    .level   (level),
    .clear   (ack_done),
    .pending (pending),
    .irq_req (irq_req)
  );

  irqr_ack_fsm #(.CFG_W(CFG_W), .ADR_W(ADR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ack_s_n     (bus_s[4]),
    .chain_s_n   (bus_s[3]),
    .as_s_n      (bus_s[2]),
    .ds_s_n      (bus_s[1:0]),
    .lvl_addr    (lvl_addr),
    .level       (level),
    .vector      (vector),
    .pending     (pending),
    .vec_out     (vec_out),
    .xfer_ack_en (xfer_ack_en),
    .chain_out_n (chain_out_n),
    .ack_done    (ack_done)
  );

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
  parameter int LEVELS = 7,
  parameter int CFG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_evt,
  input logic [LEVELS-1:0] irq_req,
  input logic [CFG_W-1:0]  level,
  input logic [CFG_W-1:0]  vec_out,
  input logic              xfer_ack_en,
  input logic              chain_out_n
);

  assert_onehot_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req));

  assert_disabled_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((level == '0) || (level > CFG_W'(LEVELS))) |-> (irq_req == '0));

  assert_ack_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_ack_en) |-> ($past(irq_req) != '0));

  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_ack_en) |-> ((irq_req == '0) || $past(int_evt)));

  assert_no_idle_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ack_en |-> (vec_out == '0));

  assert_no_pass_while_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack_en |-> chain_out_n);

endmodule

bind irqr_top irqr_chk #(.LEVELS(LEVELS), .CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .int_evt     (int_evt),
  .irq_req     (irq_req),
  .level       (level),
  .vec_out     (vec_out),
  .xfer_ack_en (xfer_ack_en),
  .chain_out_n (chain_out_n)
);

// File: tb/tb_irqr_top.sv
module tb_irqr_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       int_evt;
  logic       cfg_we;
  logic       cfg_sel;
  logic [7:0] cfg_wdata;
  logic [6:0] irq_req;
  logic       ack_cycle_n;
  logic       chain_in_n;
  logic       chain_out_n;
  logic       addr_strobe_n;
  logic [1:0] data_strobe_n;
  logic [2:0] lvl_addr;
  logic [7:0] vec_out;
  logic       xfer_ack_en;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  irqr_top dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_evt       (int_evt),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .irq_req       (irq_req),
    .ack_cycle_n   (ack_cycle_n),
    .chain_in_n    (chain_in_n),
    .chain_out_n   (chain_out_n),
    .addr_strobe_n (addr_strobe_n),
    .data_strobe_n (data_strobe_n),
    .lvl_addr      (lvl_addr),
    .vec_out       (vec_out),
    .xfer_ack_en   (xfer_ack_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] vec_for(input int lvl);
    return 8'hA0 ^ 8'(lvl * 8'h11);
  endfunction

  function automatic int req_for(input int lvl);
    return (lvl >= 1 && lvl <= 7) ? (1 << (lvl - 1)) : 0;
  endfunction

  task automatic cfg_write(input bit sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    int_evt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    int_evt = 1'b0;
  endtask

  task automatic run_ack(input int a, input bit resp, input logic [7:0] expv,
                         input int irq_after, input bit split);
    @(negedge clk);
    lvl_addr = 3'(a); ack_cycle_n = 1'b0; chain_in_n = 1'b0;
    addr_strobe_n = 1'b0; data_strobe_n = 2'b10;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 latency ack", int'(xfer_ack_en), 0);
    check("R5 latency chain", int'(chain_out_n), 1);
    @(posedge clk);
    @(negedge clk);
    if (resp) begin
      check("R5 ack", int'(xfer_ack_en), 1);
      check("R5 vector", int'(vec_out), int'(expv));
      check("R7 chain held", int'(chain_out_n), 1);
    end else begin
      check("R7 pass chain", int'(chain_out_n), 0);
      check("R7 no ack", int'(xfer_ack_en), 0);
      check("R7 no vector", int'(vec_out), 0);
    end
    if (split) begin
      data_strobe_n = 2'b01;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R6 held on one strobe", int'(xfer_ack_en), 1);
      check("R6 vector held", int'(vec_out), int'(expv));
    end
    data_strobe_n = 2'b11; addr_strobe_n = 1'b1;
    ack_cycle_n = 1'b1; chain_in_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (resp) check("R6 hold before release", int'(xfer_ack_en), 1);
    else      check("R10 chain hold", int'(chain_out_n), 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 ack released", int'(xfer_ack_en), 0);
    check("R6 vector released", int'(vec_out), 0);
    check("R10 chain released", int'(chain_out_n), 1);
    check("R6 request after cycle", int'(irq_req), irq_after);
  endtask

  initial begin
    rst_n = 1'b0; int_evt = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    ack_cycle_n = 1'b1; chain_in_n = 1'b1; addr_strobe_n = 1'b1;
    data_strobe_n = 2'b11; lvl_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq", int'(irq_req), 0);
    check("R1 vec", int'(vec_out), 0);
    check("R1 ack", int'(xfer_ack_en), 0);
    check("R1 chain", int'(chain_out_n), 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // default vector, level 3
    cfg_write(1'b0, 8'd3);
    pulse_evt();
    check("R2 level3 request", int'(irq_req), 7'b0000100);
    run_ack(3, 1'b1, 8'h00, 0, 1'b0);   // R4
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R8 stays clear", int'(irq_req), 0);
    pulse_evt();
    check("R8 new event", int'(irq_req), 7'b0000100);
    run_ack(3, 1'b1, 8'h00, 0, 1'b0);

    // sweep every level against every acknowledged level
    for (int lvl = 1; lvl <= 7; lvl++) begin
      cfg_write(1'b1, vec_for(lvl));
      cfg_write(1'b0, 8'(lvl));
      check("R8 no request before event", int'(irq_req), 0);
      pulse_evt();
      check("R2 request bit", int'(irq_req), req_for(lvl));
      for (int a = 0; a <= 7; a++) begin
        if (a != lvl) run_ack(a, 1'b0, 8'h00, req_for(lvl), 1'b0);  // R7 mismatch
      end
      run_ack(lvl, 1'b1, vec_for(lvl), 0, lvl == 5);                 // R5 R6
      run_ack(lvl, 1'b0, 8'h00, 0, 1'b0);                            // R7 none pending
    end

    // R9 register independence
    cfg_write(1'b0, 8'd2);
    pulse_evt();
    cfg_write(1'b1, 8'h5A);
    check("R9 vector write keeps request", int'(irq_req), 7'b0000010);
    run_ack(2, 1'b1, 8'h5A, 0, 1'b0);
    cfg_write(1'b0, 8'd6);
    pulse_evt();
    check("R9 level write keeps vector path", int'(irq_req), 7'b0100000);
    run_ack(6, 1'b1, 8'h5A, 0, 1'b0);

    // R3 disabled levels
    for (int bad = 0; bad < 3; bad++) begin
      cfg_write(1'b0, (bad == 0) ? 8'd0 : ((bad == 1) ? 8'd8 : 8'hFF));
      pulse_evt();
      check("R3 disabled request", int'(irq_req), 0);
    end
    cfg_write(1'b0, 8'd4);
    check("R3 no latent request", int'(irq_req), 0);
    run_ack(4, 1'b0, 8'h00, 0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule